// File: doc/BRIEF.md
# Shared General-Purpose I/O Port with Peripheral Override

This block is a 16-pin general-purpose I/O port that sits on a processor's register bus. Software controls each pin through four registers: a direction register, an output data latch, an analog configuration mask, and the port view of the pins. A pin whose direction bit is 1 is an input and its driver is off. A pin whose direction bit is 0 drives the latch bit onto the pad. Pins marked as analog always read back as 0 through the port view, whatever level is on the pad.

Any pin can be taken over by a peripheral. While a pin's peripheral enable is high, the peripheral's data and enable drive that pin in place of the latch and direction bits. The peripheral always sees the live level of every pad.

Each pad is modelled as a separate output value, output enable and input level, so that a tristate cell can be placed outside the block. Pad inputs pass through one sampling register before they reach the read path. As a result, a port read in the cycle right after a write or a direction change still returns the old pin state. The new state is visible from the second cycle on.

Top module: `gpio_shared_port`

## Requirements
- R1: Synchronous reset sets every direction bit to 1, the latch to 0 and every analog bit to 1. After reset, a port read returns 0 and no pad is driven.
- R2: With no peripheral override, pad_oe for a pin is 1 when its direction bit is 0 and 0 when its direction bit is 1. reg_sel 0 writes and reads the direction register.
- R3: A write with reg_sel 1 (latch) or reg_sel 2 (port) loads wr_data into the output latch on that clock edge. A read with reg_sel 1 returns the latch contents. The latch holds its value while wr_en is low.
- R4: A read with reg_sel 2 returns the pad levels captured at the previous clock edge. A read in the cycle directly after a latch or direction write returns the pre-write pin state, and a read one cycle later returns the new state.
- R5: Every pin whose analog bit is 1 reads as 0 through reg_sel 2, whatever its pad level.
- R6: When periph_en[i] is 1, pad_out[i] equals periph_out[i] and pad_oe[i] equals periph_oe[i], whatever the latch and direction bits are.
- R7: periph_in always equals the current pad input levels, whatever the direction, analog and override settings are.
- R8: reg_sel 3 writes and reads the analog configuration mask.
- R9: A write to the port address changes neither the direction register nor the analog mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 direction, 1 latch, 2 port, 3 analog |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register, valid in the same cycle |
| periph_en | input | 16 | Per-pin peripheral override enable |
| periph_out | input | 16 | Peripheral output data |
| periph_oe | input | 16 | Peripheral output enable |
| periph_in | output | 16 | Pad input levels passed to the peripheral |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad driver enable, 1 drives the pad |
| pad_in | input | 16 | Level sensed on each pad |

## Verification
The two functions that meet in adjacent cycles are a write to the latch or to the direction register, and a port read of the same pins. The bench models the pads as a loopback: a driven pad shows its output value, and an undriven pad shows a level set by the bench. It issues a port-address write, or a direction change, and reads the port in the very next cycle, where it expects the previously sampled levels. It reads again one cycle later and expects the new levels. The same loopback is used with peripheral override and analog masking active, to show that the overridden pads and the masked read bits follow their own rules rather than the latch.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_ANA  = 2'd3
  } port_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  port_sel_e    sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] ana_q
);
  logic dir_we, lat_we, ana_we;

  assign dir_we = wr_en && (sel == SEL_DIR);
  assign lat_we = wr_en && ((sel == SEL_LAT) || (sel == SEL_PORT));
  assign ana_we = wr_en && (sel == SEL_ANA);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= '1;
    end else begin
      if (dir_we) dir_q <= wr_data;
      if (lat_we) lat_q <= wr_data;
      if (ana_we) ana_q <= wr_data;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dir_q == '1 && lat_q == '0 && ana_q == '1));

  assert_latch_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (sel == SEL_LAT || sel == SEL_PORT)) |=> lat_q == $past(wr_data));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(lat_q));

  assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_DIR) |=> dir_q == $past(wr_data));

  assert_ana_load_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_ANA) |=> ana_q == $past(wr_data));

  assert_port_keeps_cfg_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_PORT) |=> ($stable(dir_q) && $stable(ana_q)));
endmodule

// File: rtl/gpio_pin_sampler.sv
module gpio_pin_sampler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] ana_q,
  output logic [W-1:0] port_view
);
  logic [W-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pad_in;
  end

  assign port_view = pin_q & ~ana_q;
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 16
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] periph_en,
  input  logic [W-1:0] periph_out,
  input  logic [W-1:0] periph_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (periph_en[i]) begin
        pad_out[i] = periph_out[i];
        pad_oe[i]  = periph_oe[i];
      end else begin
        pad_out[i] = lat_q[i];
        pad_oe[i]  = ~dir_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   reg_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] periph_en,
  input  logic [W-1:0] periph_out,
  input  logic [W-1:0] periph_oe,
  output logic [W-1:0] periph_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] pad_in
);
  port_sel_e    sel;
  logic [W-1:0] dir_q, lat_q, ana_q, port_view;

  assign sel = port_sel_e'(reg_sel);

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q)
  );

  gpio_pin_sampler #(.W(W)) u_sampler (
    .clk(clk), .rst(rst), .pad_in(pad_in), .ana_q(ana_q), .port_view(port_view)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .dir_q(dir_q), .lat_q(lat_q), .periph_en(periph_en),
    .periph_out(periph_out), .periph_oe(periph_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign periph_in = pad_in;

  always_comb begin
    unique case (sel)
      SEL_DIR:  rd_data = dir_q;
      SEL_LAT:  rd_data = lat_q;
      SEL_PORT: rd_data = port_view;
      SEL_ANA:  rd_data = ana_q;
      default:  rd_data = '0;
    endcase
  end

  assert_analog_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_PORT) |-> ((rd_data & ana_q) == '0));

  assert_port_lags_pad_R4: assert property (@(posedge clk) disable iff (rst)
    ((sel == SEL_PORT) && $past(!rst)) |-> (rd_data == ($past(pad_in) & ~ana_q)));
endmodule

// File: tb/gpio_shared_port_tb.sv
module gpio_shared_port_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   reg_sel = 2'd0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] periph_en = '0;
  logic [W-1:0] periph_out = '0;
  logic [W-1:0] periph_oe = '0;
  logic [W-1:0] periph_in;
  logic [W-1:0] pad_out, pad_oe, pad_in;
  logic [W-1:0] ext_level = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_level);

  gpio_shared_port #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .periph_en(periph_en), .periph_out(periph_out),
    .periph_oe(periph_oe), .periph_in(periph_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_now(input logic [1:0] s, output logic [W-1:0] v);
    reg_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    read_now(2'd0, v); check("R1 dir reset", v, 16'hFFFF);
    read_now(2'd1, v); check("R1 latch reset", v, 16'h0000);
    read_now(2'd3, v); check("R1 analog reset", v, 16'hFFFF);
    read_now(2'd2, v); check("R1 port reset", v, 16'h0000);
    check("R1 pad_oe reset", pad_oe, 16'h0000);
  endtask

  task automatic t_dir_latch;
    logic [W-1:0] v;
    ext_level = 16'h1234;
    write_reg(2'd3, 16'h0000);
    write_reg(2'd0, 16'hFF00);
    write_reg(2'd1, 16'hA5C3);
    read_now(2'd1, v); check("R3 latch readback", v, 16'hA5C3);
    read_now(2'd0, v); check("R2 dir readback", v, 16'hFF00);
    check("R2 pad_oe from dir", pad_oe, 16'h00FF);
    wait_cycles(2);
    read_now(2'd2, v); check("R4 mixed port read", v, 16'h12C3);
  endtask

  task automatic t_port_write_latency;
    logic [W-1:0] v;
    write_reg(2'd2, 16'h005A);
    read_now(2'd2, v); check("R4 read next cycle old", v, 16'h12C3);
    wait_cycles(1);
    read_now(2'd2, v); check("R4 read second cycle new", v, 16'h125A);
    read_now(2'd1, v); check("R3 port address loads latch", v, 16'h005A);
    read_now(2'd0, v); check("R9 dir kept after port write", v, 16'hFF00);
    read_now(2'd3, v); check("R9 analog kept after port write", v, 16'h0000);
  endtask

  task automatic t_dir_change_latency;
    logic [W-1:0] v;
    write_reg(2'd0, 16'hFFFF);
    check("R2 all inputs undriven", pad_oe, 16'h0000);
    read_now(2'd2, v); check("R4 dir change next cycle old", v, 16'h125A);
    wait_cycles(1);
    read_now(2'd2, v); check("R4 dir change second cycle new", v, 16'h1234);
  endtask

  task automatic t_analog;
    logic [W-1:0] v;
    write_reg(2'd3, 16'h0F0F);
    read_now(2'd3, v); check("R8 analog readback", v, 16'h0F0F);
    wait_cycles(1);
    read_now(2'd2, v); check("R5 analog pins read zero", v, 16'h1030);
    ext_level = 16'hFFFF;
    wait_cycles(2);
    read_now(2'd2, v); check("R5 analog high pins read zero", v, 16'hF0F0);
  endtask

  task automatic t_periph;
    logic [W-1:0] v;
    write_reg(2'd3, 16'h0000);
    write_reg(2'd0, 16'h0000);
    write_reg(2'd1, 16'hFFFF);
    @(negedge clk);
    ext_level = 16'h0000;
    periph_en = 16'h00F0; periph_out = 16'h0050; periph_oe = 16'h00C0;
    #1;
    check("R6 pad_oe override", pad_oe, 16'hFFCF);
    check("R6 pad_out override", pad_out, 16'hFF5F);
    check("R7 periph_in driven", periph_in, 16'hFF4F);
    ext_level = 16'h0030;
    #1;
    check("R7 periph_in external", periph_in, 16'hFF7F);
    wait_cycles(2);
    read_now(2'd2, v); check("R6 port read under override", v, 16'hFF7F);
    write_reg(2'd1, 16'h0000);
    check("R6 overridden pins ignore latch", pad_out, 16'h0050);
    periph_en = 16'h0000;
    #1;
    check("R6 override released", pad_out, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dir_latch();
    t_port_write_latency();
    t_dir_change_latency();
    t_analog();
    t_periph();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule